// File: doc/BRIEF.md
# Cross-Domain CPU Event Pulse Generator

This block carries a wake-up event request from the bus-clock domain into the free-running clock domain of one processor. There it becomes exactly one single-cycle pulse for the processor's receive-event input. On the bus side, a rising edge of the combined event request input sets a held request level.

On the processor side, the held level is treated as asynchronous. It passes through a multi-flop synchronizer and its rising edge becomes one event pulse. The processor side then drives a return reset, and that reset clears the bus-side level asynchronously. The return reset is released once the synchronized level has gone low, which rearms the path for the next request.

A request edge that arrives while the level is still held is folded into the request already in flight. A system with several processors instantiates the block once per processor, each copy on its own processor clock.

Top module: `cpu_evt_xfer`

## Requirements
- R1: While reset is asserted and after reset is released with no request activity, `req_level` and `cpu_event` are both 0.
- R2: A 0-to-1 transition of `evt_in`, sampled on `bus_clk`, drives `req_level` high at the next `bus_clk` rising edge.
- R3: A constant high level on `evt_in` is not a request. Holding `evt_in` at 1 for any number of cycles yields only the one pulse of its initial rising edge.
- R4: `req_level` stays high until the return reset clears it. It is low no later than one `cpu_clk` cycle after the event pulse has been issued.
- R5: Each accepted request produces `cpu_event` high for exactly one `cpu_clk` cycle. The pulse starts within `SYNC_STAGES`+2 `cpu_clk` cycles after `req_level` rises.
- R6: A further rising edge of `evt_in` while `req_level` is high is merged with the pending request and produces no additional pulse.
- R7: `cpu_event` is never high while the return reset is active. No pulse occurs without a preceding request.
- R8: After a completed handshake, a new rising edge of `evt_in` produces a new pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus clock; source side of the handshake |
| cpu_clk | input | 1 | Free-running processor clock; destination side |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| evt_in | input | 1 | OR of this processor's event requests, synchronous to `bus_clk` |
| req_level | output | 1 | Held request level in the bus domain |
| cpu_event | output | 1 | Single-cycle event pulse, synchronous to `cpu_clk` |

## Verification
The hardest case to reach from the ports is merging: a second rising edge has to arrive while the first request is still held, before the return reset has cleared it. The stimulus gets there with a directed sequence of high, low, high on `evt_in` on consecutive bus cycles. Before it drives the second rise, it confirms at the port that `req_level` is still high, and then expects a single pulse. The bus and processor clocks run at unrelated periods, and random hold and gap lengths move the request edge through every phase of the processor clock.

// File: rtl/cpu_evt_pkg.sv
package cpu_evt_pkg;
   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MAX_SYNC_STAGES = 6;
endpackage

// File: rtl/cevt_src_flag.sv
module cevt_src_flag (
   input  logic bus_clk,
   input  logic rst_n,
   input  logic evt_in,
   input  logic ack_in,
   output logic flag_o
);
   logic evt_prev;
   logic evt_rise;

   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) evt_prev <= 1'b0;
      else        evt_prev <= evt_in;
   end

   assign evt_rise = evt_in & ~evt_prev;

   // held level; the destination's return reset clears it without waiting for bus_clk
   always_ff @(posedge bus_clk or negedge rst_n or posedge ack_in) begin
      if (!rst_n)        flag_o <= 1'b0;
      else if (ack_in)   flag_o <= 1'b0;
      else if (evt_rise) flag_o <= 1'b1;
   end

   // R2
   flag_needs_input_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(evt_in));
endmodule

// File: rtl/cevt_sync.sv
module cevt_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   import cpu_evt_pkg::*;
   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < MIN_SYNC_STAGES || STAGES > MAX_SYNC_STAGES) begin : g_bad_depth
         $error("cevt_sync: STAGES out of range");
      end
   endgenerate

   logic [LAST:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= d;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[LAST];
endmodule

// File: rtl/cevt_dst_pulse.sv
module cevt_dst_pulse (
   input  logic cpu_clk,
   input  logic rst_n,
   input  logic lvl_sync,
   output logic evt_o,
   output logic ack_o
);
   logic lvl_prev;

   always_ff @(posedge cpu_clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev <= 1'b0;
         evt_o    <= 1'b0;
         ack_o    <= 1'b0;
      end else begin
         lvl_prev <= lvl_sync;
         evt_o    <= lvl_sync & ~lvl_prev & ~ack_o;
         // raised after the pulse, held until the synchronized level is seen low
         ack_o    <= evt_o | (ack_o & lvl_sync);
      end
   end

   // R5
   pulse_one_cycle_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      evt_o |=> !evt_o);
   // R4
   ack_after_pulse_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      evt_o |=> ack_o);
   // R7
   no_pulse_in_ack_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      ack_o |-> !evt_o);
   // R7
   ack_has_cause_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(evt_o));
endmodule

// File: rtl/cpu_evt_xfer.sv
module cpu_evt_xfer #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic bus_clk,
   input  logic cpu_clk,
   input  logic rst_n,
   input  logic evt_in,
   output logic req_level,
   output logic cpu_event
);
   logic flag;
   logic flag_sync;
   logic ack;

   cevt_src_flag u_src (
      .bus_clk (bus_clk),
      .rst_n   (rst_n),
      .evt_in  (evt_in),
      .ack_in  (ack),
      .flag_o  (flag)
   );

   cevt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (cpu_clk),
      .rst_n (rst_n),
      .d     (flag),
      .q     (flag_sync)
   );

   cevt_dst_pulse u_dst (
      .cpu_clk  (cpu_clk),
      .rst_n    (rst_n),
      .lvl_sync (flag_sync),
      .evt_o    (cpu_event),
      .ack_o    (ack)
   );

   assign req_level = flag;

   // R1
   always_comb begin
      if (!rst_n) begin
         out_idle_in_reset_chk: assert (!cpu_event && !req_level);
      end
   end
endmodule

// File: tb/sim_cpu_evt_xfer.sv
`timescale 1ns/1ps
module sim_cpu_evt_xfer;
   localparam int unsigned SYNC = 2;
   localparam int unsigned LAT_MAX = SYNC + 2;

   logic bus_clk = 1'b0;
   logic cpu_clk = 1'b0;
   logic rst_n   = 1'b0;
   logic evt_in  = 1'b0;
   logic req_level;
   logic cpu_event;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int wide_err = 0;
   int expected = 0;
   bit prev_hi = 1'b0;
   bit finished = 1'b0;

   always #5   bus_clk = ~bus_clk;
   always #3.5 cpu_clk = ~cpu_clk;

   cpu_evt_xfer #(.SYNC_STAGES(SYNC)) u0 (
      .bus_clk(bus_clk), .cpu_clk(cpu_clk), .rst_n(rst_n),
      .evt_in(evt_in), .req_level(req_level), .cpu_event(cpu_event)
   );

   always @(negedge cpu_clk) begin
      if (cpu_event) begin
         if (!prev_hi) pulses++;
         else          wide_err++;
      end
      prev_hi = cpu_event;
   end

   function automatic bit same(int a, int b);
      return a == b;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_cycles(int n);
      for (int i = 0; i < n; i++) @(negedge bus_clk);
   endtask

   // drives one rising edge, checks set, latency, pulse and clear
   task automatic one_request(int hold, int gap, string req);
      int lat = 0;
      int base = pulses;
      @(negedge bus_clk);
      evt_in = 1'b1;
      @(negedge bus_clk);
      check(req_level == 1'b1, "R2 level set", int'(req_level), 1);
      while (pulses == base && lat <= LAT_MAX + 2) begin
         @(negedge cpu_clk);
         lat++;
      end
      check(lat <= LAT_MAX + 1, "R5 latency", lat, LAT_MAX + 1);
      @(negedge cpu_clk);
      check(req_level == 1'b0, "R4 cleared after pulse", int'(req_level), 0);
      bus_cycles(hold);
      evt_in = 1'b0;
      bus_cycles(gap);
      expected++;
      check(same(pulses, expected), req, pulses, expected);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      #1;
      check(req_level == 1'b0 && cpu_event == 1'b0, "R1 during reset", int'(req_level), 0);
      #40 rst_n = 1'b1;
      bus_cycles(10);
      check(req_level == 1'b0, "R1 after reset level", int'(req_level), 0);
      check(pulses == 0, "R1/R7 no pulse after reset", pulses, 0);

      // basic
      one_request(1, 10, "R5 single pulse");
      // long high hold: only one pulse (R3)
      one_request(40, 10, "R3 steady high");
      bus_cycles(20);
      check(same(pulses, expected), "R3 no pulse from level", pulses, expected);

      // merge: high, low, high while still held (R6)
      @(negedge bus_clk); evt_in = 1'b1;
      @(negedge bus_clk); evt_in = 1'b0;
      @(negedge bus_clk);
      check(req_level == 1'b1, "R6 still held before merge", int'(req_level), 1);
      evt_in = 1'b1;
      @(negedge bus_clk); evt_in = 1'b0;
      bus_cycles(15);
      expected++;
      check(same(pulses, expected), "R6 merged edges", pulses, expected);

      // rearm soon after completion (R8)
      one_request(1, 8, "R8 rearm first");
      one_request(1, 8, "R8 rearm second");

      // constrained random hold and gap
      for (int k = 0; k < 40; k++) begin
         int h = 1 + int'($urandom_range(0, 12));
         int g = 8 + int'($urandom_range(0, 9));
         one_request(h, g, "R5 random pulse count");
      end

      check(wide_err == 0, "R5 pulse width", wide_err, 0);
      check(req_level == 1'b0 && cpu_event == 1'b0, "R7 quiet at end", int'(req_level), 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule